// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register storage of a processor core with seven operating modes. The core presents its current mode, two read indices and one write index, each naming one of sixteen logical registers. The block translates every index into a physical storage slot that depends on the mode. Five of the modes are exception modes, and each has private copies of some high-numbered registers. The fast-interrupt mode privatises a larger range of registers than the other exception modes.

The block also keeps a saved-status word for each of the five exception modes. That word has its own read output and its own write strobe. The program counter (logical 15) is only a shared storage slot here. Instruction decode, the ALU and the current-status register are outside the block.

Top module: `mode_banked_regfile`

## Requirements
- R1: After a synchronous active-high reset, every logical register reads zero in every mode on both ports, and the saved-status output reads zero.
- R2: Logical registers 0 to 7 and 15 map to one physical copy each, shared by all modes. A value written in any mode reads back identically in every other mode. In user mode (10000), registers 8 to 14 are the user copies.
- R3: In fast-interrupt mode (10001), logical registers 8 to 14 are private copies. Writes to them in other modes are not visible there, and writes made there are not visible elsewhere.
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private copies of logical 13 and 14. For logical 8 to 12 they use the user copies.
- R5: System mode (11111) reads and writes exactly the user-mode copies of all sixteen registers.
- R6: Each of the five exception modes has its own saved-status word. In that mode, a write with the saved-status strobe is read back only in that mode.
- R7: In user or system mode the saved-status output is zero, and a saved-status write changes none of the five stored words.
- R8: A register write takes effect at the clock edge. A read of the same physical register in the write cycle returns the old value, and the new value appears after the edge.
- R9: Any mode value other than the seven listed maps registers exactly as user mode and behaves as user mode for saved status.
- R10: Both read ports decode independently, so different indices in the same cycle return their own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current operating mode |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | DATA_W | Read port A data (combinational) |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | DATA_W | Register write data |
| sps_rd_data | output | DATA_W | Saved-status word of the current mode |
| sps_wr_en | input | 1 | Saved-status write strobe |
| sps_wr_data | input | DATA_W | Saved-status write data |

## Verification
The bench builds the block with its default 32-bit data width. At that size the whole logical space is small: sixteen indices in seven modes plus three unrecognised mode codes. The bench therefore writes every index in every mode and then reads all sixteen indices back on both ports in every mode. It compares each value with an expected model that copies a write to every mode that shares that register. This catches any sharing error between banks, including the wider fast-interrupt bank and the fallback for unknown modes.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

    localparam int MODE_W        = 5;
    localparam int LOG_W         = 4;
    localparam int N_LOW_SHARED  = 8;
    localparam int PC_IDX        = 15;
    localparam int FIRST_SP      = 13;
    localparam int N_HI          = 7;
    localparam int N_EXC_PRIV    = 2;
    localparam int N_EXC_BANKS   = 4;
    localparam int N_SPS         = 5;
    localparam int PHYS_PC       = N_LOW_SHARED;
    localparam int PHYS_USR_BASE = PHYS_PC + 1;
    localparam int PHYS_FIQ_BASE = PHYS_USR_BASE + N_HI;
    localparam int PHYS_EXC_BASE = PHYS_FIQ_BASE + N_HI;
    localparam int NPHYS         = PHYS_EXC_BASE + N_EXC_BANKS * N_EXC_PRIV;
    localparam int PHYS_W        = $clog2(NPHYS);
    localparam int SPS_W         = $clog2(N_SPS);

    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [LOG_W-1:0]  lidx_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        logic  en;
        phys_t idx;
    } phys_wr_t;

    function automatic bank_e mode_to_bank(logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BK_FIQ;
            MODE_IRQ: return BK_IRQ;
            MODE_SVC: return BK_SVC;
            MODE_ABT: return BK_ABT;
            MODE_UND: return BK_UND;
            default:  return BK_USR;
        endcase
    endfunction

    function automatic phys_t phys_index(bank_e b, lidx_t r);
        int ri;
        int n;
        ri = int'(r);
        if (ri < N_LOW_SHARED)
            n = ri;
        else if (ri == PC_IDX)
            n = PHYS_PC;
        else if (b == BK_FIQ)
            n = PHYS_FIQ_BASE + ri - N_LOW_SHARED;
        else if (b != BK_USR && ri >= FIRST_SP)
            n = PHYS_EXC_BASE + (int'(b) - int'(BK_IRQ)) * N_EXC_PRIV + ri - FIRST_SP;
        else
            n = PHYS_USR_BASE + ri - N_LOW_SHARED;
        return phys_t'(n);
    endfunction

endpackage

// File: rtl/mbrf_bank_decode.sv
module mbrf_bank_decode
    import mbrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              sps_valid
);

    always_comb begin
        bank      = mode_to_bank(mode);
        sps_valid = (bank != BK_USR);
    end

    assert_sys_is_user_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SYS) |-> (bank == BK_USR && !sps_valid));

    assert_unknown_is_user_R9: assert property (@(posedge clk) disable iff (rst)
        !(mode inside {MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND, MODE_SYS})
        |-> (bank == BK_USR));

endmodule

// File: rtl/mbrf_phys_map.sv
module mbrf_phys_map
    import mbrf_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_e            bank,
    input  lidx_t [NPORT-1:0] lidx,
    output phys_t [NPORT-1:0] pidx
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_comb pidx[p] = phys_index(bank, lidx[p]);

        assert_fiq_private_R3: assert property (@(posedge clk) disable iff (rst)
            (bank == BK_FIQ && int'(lidx[p]) >= N_LOW_SHARED && int'(lidx[p]) != PC_IDX)
            |-> (int'(pidx[p]) >= PHYS_FIQ_BASE && int'(pidx[p]) < PHYS_EXC_BASE));
    end

endmodule

// File: rtl/mbrf_regstore.sv
module mbrf_regstore
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  phys_wr_t                    wr,
    input  logic [DATA_W-1:0]           wr_data,
    input  phys_t [NRD-1:0]             rd_idx,
    output logic  [NRD-1:0][DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (wr.en) begin
            mem[wr.idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb rd_data[p] = mem[rd_idx[p]];
    end

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> (mem[$past(wr.idx)] == $past(wr_data)));

endmodule

// File: rtl/mbrf_sps_bank.sv
module mbrf_sps_bank
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_e             bank,
    input  logic              valid,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [N_SPS-1:0][DATA_W-1:0] sps_q;
    logic [SPS_W-1:0]             sel;

    always_comb sel = valid ? SPS_W'(int'(bank) - 1) : '0;

    always_ff @(posedge clk) begin
        if (rst)
            sps_q <= '0;
        else if (wr_en && valid)
            sps_q[sel] <= wr_data;
    end

    always_comb rd_data = valid ? sps_q[sel] : '0;

    assert_sps_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bank == BK_USR) |=> (sps_q == $past(sps_q)));

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
    import mbrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sps_rd_data,
    input  logic              sps_wr_en,
    input  logic [DATA_W-1:0] sps_wr_data
);

    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;

    bank_e                     bank;
    logic                      sps_valid;
    lidx_t [NPORT-1:0]         lidx;
    phys_t [NPORT-1:0]         pidx;
    phys_t [NRD-1:0]           rd_pidx;
    logic  [NRD-1:0][DATA_W-1:0] rd_data;
    phys_wr_t                  wr_req;

    mbrf_bank_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_i),
        .bank      (bank),
        .sps_valid (sps_valid)
    );

    always_comb begin
        lidx[0] = rd_a_idx;
        lidx[1] = rd_b_idx;
        lidx[2] = wr_idx;
    end

    mbrf_phys_map #(.NPORT(NPORT)) u_map (
        .clk  (clk),
        .rst  (rst),
        .bank (bank),
        .lidx (lidx),
        .pidx (pidx)
    );

    always_comb begin
        rd_pidx[0] = pidx[0];
        rd_pidx[1] = pidx[1];
        wr_req.en  = wr_en;
        wr_req.idx = pidx[2];
    end

    mbrf_regstore #(.DATA_W(DATA_W), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .wr_data (wr_data),
        .rd_idx  (rd_pidx),
        .rd_data (rd_data)
    );

    always_comb begin
        rd_a_data = rd_data[0];
        rd_b_data = rd_data[1];
    end

    mbrf_sps_bank #(.DATA_W(DATA_W)) u_sps (
        .clk     (clk),
        .rst     (rst),
        .bank    (bank),
        .valid   (sps_valid),
        .wr_en   (sps_wr_en),
        .wr_data (sps_wr_data),
        .rd_data (sps_rd_data)
    );

    assert_sps_zero_user_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_USR || mode_i == MODE_SYS) |-> (sps_rd_data == '0));

endmodule

// File: tb/mode_banked_regfile_test.sv
module mode_banked_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NMODES = 10;
    localparam logic [4:0] MODES [NMODES] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
        5'b10111, 5'b11011, 5'b11111, 5'b00000, 5'b10100, 5'b11110};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    mode_i = 5'b10000;
    logic [3:0]    rd_a_idx = '0;
    logic [3:0]    rd_b_idx = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          sps_wr_en = 1'b0;
    logic [DW-1:0] sps_wr_data = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, sps_rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] ref_reg [6][16];
    logic [DW-1:0] ref_sps [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_banked_regfile #(.DATA_W(DW)) uut (
        .clk (clk), .rst (rst), .mode_i (mode_i),
        .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
        .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
        .sps_rd_data (sps_rd_data), .sps_wr_en (sps_wr_en), .sps_wr_data (sps_wr_data)
    );

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic bit shares(int b, int wb, int i);
        if (i < 8 || i == 15) return 1'b1;
        if (i <= 12) return (b == 1) == (wb == 1);
        return b == wb;
    endfunction

    function automatic string tag_for(logic [4:0] m, int i);
        int b;
        b = bank_of(m);
        if (i < 8 || i == 15) return "R2";
        if (b == 1) return "R3";
        if (b >= 2) return "R4";
        if (m == 5'b11111) return "R5";
        if (m != 5'b10000) return "R9";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_write(logic [4:0] m, int i, logic [DW-1:0] d);
        for (int b = 0; b < 6; b++)
            if (shares(b, bank_of(m), i)) ref_reg[b][i] = d;
    endtask

    task automatic do_write(logic [4:0] m, int i, logic [DW-1:0] d);
        @(negedge clk);
        mode_i = m; wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(m, i, d);
    endtask

    task automatic sweep_reads(string tag_override);
        for (int mi = 0; mi < NMODES; mi++) begin
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                mode_i = MODES[mi];
                rd_a_idx = 4'(i);
                rd_b_idx = 4'(15 - i);
                #1;
                check(tag_override == "" ? tag_for(MODES[mi], i) : tag_override,
                      rd_a_data, ref_reg[bank_of(MODES[mi])][i]);
                check(tag_override == "" ? "R10" : tag_override,
                      rd_b_data, ref_reg[bank_of(MODES[mi])][15 - i]);
            end
        end
    endtask

    task automatic sweep_sps(string tag);
        for (int mi = 0; mi < NMODES; mi++) begin
            @(negedge clk);
            mode_i = MODES[mi];
            #1;
            check(bank_of(MODES[mi]) == 0 ? "R7" : tag, sps_rd_data, ref_sps[bank_of(MODES[mi])]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 6; b++) begin
            ref_sps[b] = '0;
            for (int i = 0; i < 16; i++) ref_reg[b][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state everywhere
        sweep_reads("R1");
        sweep_sps("R1");

        // R2 R3 R4 R5 R9 R10: write every index in every mode code, then read all back
        for (int pass = 0; pass < 2; pass++) begin
            for (int mi = 0; mi < NMODES; mi++) begin
                int mo;
                mo = (pass == 0) ? mi : NMODES - 1 - mi;
                for (int i = 0; i < 16; i++)
                    do_write(MODES[mo], i, {8'(8'hC0 + pass), 3'd0, MODES[mo], 12'h5A0, 4'(i)});
                sweep_reads("");
            end
        end

        // R6: distinct saved-status word per exception mode
        for (int mi = 0; mi < NMODES; mi++) begin
            logic [DW-1:0] d;
            d = {16'hB00C, 11'd0, MODES[mi]};
            @(negedge clk);
            mode_i = MODES[mi]; sps_wr_en = 1'b1; sps_wr_data = d;
            @(negedge clk);
            sps_wr_en = 1'b0;
            if (bank_of(MODES[mi]) != 0) ref_sps[bank_of(MODES[mi])] = d;
            sweep_sps("R6");
        end

        // R8: same-cycle read returns old value, new value after the edge
        for (int i = 0; i < 16; i++) begin
            logic [DW-1:0] oldv, newv;
            oldv = ref_reg[1][i];
            newv = ~oldv;
            @(negedge clk);
            mode_i = 5'b10001; rd_a_idx = 4'(i); wr_en = 1'b1; wr_idx = 4'(i); wr_data = newv;
            #1;
            check("R8", rd_a_data, oldv);
            @(posedge clk);
            #1;
            check("R8", rd_a_data, newv);
            @(negedge clk);
            wr_en = 1'b0;
            model_write(5'b10001, i, newv);
        end
        sweep_reads("");

        // R1: reset clears after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < 6; b++) begin
            ref_sps[b] = '0;
            for (int i = 0; i < 16; i++) ref_reg[b][i] = '0;
        end
        sweep_reads("R1");
        sweep_sps("R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule